// File: doc/BRIEF.md
# Single-Cycle 64-bit Load/Store Execution Core

This block executes a small subset of a 64-bit load/store instruction set, one instruction per clock. Each cycle it fetches a 32-bit word from an internal instruction memory, decodes it as one of three layouts, and retires it in the same cycle. The register layout adds or subtracts two registers. The immediate layout adds or subtracts a 12-bit unsigned constant. The data-transfer layout moves a 64-bit doubleword between a register and a byte-addressed data memory. All three layouts keep the first source register in bits [9:5] and the destination (or store-data) register in bits [4:0].

The register file holds 32 entries of 64 bits, and entry 31 is a constant zero. Both memories are internal arrays. A load port fills them while reset is held. A debug port returns any register or any doubleword of data memory one cycle after its address is given. Any instruction word the core does not recognise stops the program counter and raises `halt`, which stays high until the next reset.

Top module: `mini_ls_core`

## Requirements
- R1: A word with [31:21]=1112 and [15:10]=0 writes register [4:0] with register [9:5] plus register [20:16], modulo 2^64; the word 0x8B150289 adds X20 and X21 into X9.
- R2: A word with [31:21]=1624 and [15:10]=0 writes register [4:0] with register [9:5] minus register [20:16], modulo 2^64.
- R3: A word with [31:22]=580 writes register [4:0] with register [9:5] plus the 12-bit field [21:10] zero-extended to 64 bits.
- R4: A word with [31:22]=836 writes register [4:0] with register [9:5] minus the zero-extended field [21:10], modulo 2^64.
- R5: A word with [31:21]=1986 and [11:10]=00 loads register [4:0] from 8 bytes starting at byte address register [9:5] plus [20:12] sign-extended from 9 bits. The lowest address holds the least significant byte. Any alignment is allowed, and addresses wrap modulo the data memory size.
- R6: A word with [31:21]=1984 and [11:10]=00 stores register [4:0] into 8 bytes at the same address and byte order as R5. All other bytes are left unchanged.
- R7: Register 31 reads as zero, both as a source and on the debug port. Writes to register 31 are dropped.
- R8: Any other word writes nothing. This includes the register layout with nonzero [15:10] and the transfer layout with nonzero [11:10]. `halt` rises on the next edge, the program counter freezes, and `halt` stays high until reset.
- R9: Reset sets the program counter to 0 and clears `halt`, and keeps register and memory contents. After reset is released, the word at byte address 4k executes on rising edge k+1. With `ld_dmem`=0, the load port writes `ld_data` to instruction word `ld_addr`. With `ld_dmem`=1, it writes `ld_data[7:0]` to data byte `ld_addr`.
- R10: The debug outputs show the register or the doubleword (R5 byte order) at the address given one edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load-port target: 0 instruction word, 1 data byte |
| ld_addr | input | 9 | Instruction word index or data byte address |
| ld_data | input | 32 | Instruction word, or data byte in [7:0] |
| dbg_reg_addr | input | 5 | Register number to read |
| dbg_reg_data | output | 64 | Registered register value |
| dbg_mem_addr | input | 9 | Data byte address of doubleword to read |
| dbg_mem_data | output | 64 | Registered doubleword, little-endian |
| halt | output | 1 | Unrecognised instruction reached; core stopped |

## Verification
An addressing or byte-lane fault inside the data memory leaves wrong bytes at the store site, or in its neighbours. The doubleword debug read exposes this one cycle after the address is presented, at every byte offset. A decode or operand-select fault leaves a wrong value in a destination register, which the register debug port reads back after the program halts. An error in the program counter or the halt logic moves the edge on which `halt` rises away from the count of legal instructions in the program. It also lets later instructions alter registers or memory after an unrecognised word.

// File: rtl/mls_pkg.sv
package mls_pkg;
  localparam int XLEN    = 64;
  localparam int INSTR_W = 32;
  localparam int REG_AW  = 5;
  localparam int NREGS   = 1 << REG_AW;
  localparam int IMM_W   = 12;
  localparam int OFS_W   = 9;

  localparam logic [10:0] OPC_ADD  = 11'd1112;
  localparam logic [10:0] OPC_SUB  = 11'd1624;
  localparam logic [10:0] OPC_LOAD = 11'd1986;
  localparam logic [10:0] OPC_STOR = 11'd1984;
  localparam logic [9:0]  OPC_ADDI = 10'd580;
  localparam logic [9:0]  OPC_SUBI = 10'd836;

  typedef struct packed {
    logic [REG_AW-1:0] rn;
    logic [REG_AW-1:0] rm;
    logic [REG_AW-1:0] rd;
    logic [XLEN-1:0]   imm;
    logic              use_imm;
    logic              sub;
    logic              rf_we;
    logic              mem_rd;
    logic              mem_we;
    logic              illegal;
  } dec_t;
endpackage

// File: rtl/mls_decode.sv
module mls_decode import mls_pkg::*; (
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic [10:0] op11;
  logic [9:0]  op10;
  logic        shamt_zero;
  logic        op2_zero;

  assign op11       = instr[31:21];
  assign op10       = instr[31:22];
  assign shamt_zero = (instr[15:10] == 6'd0);
  assign op2_zero   = (instr[11:10] == 2'd0);

  always_comb begin
    dec         = '0;
    dec.rn      = instr[9:5];
    dec.rm      = instr[20:16];
    dec.rd      = instr[4:0];
    dec.illegal = 1'b1;
    if ((op11 == OPC_ADD || op11 == OPC_SUB) && shamt_zero) begin
      dec.illegal = 1'b0;
      dec.rf_we   = 1'b1;
      dec.sub     = (op11 == OPC_SUB);
    end else if (op10 == OPC_ADDI || op10 == OPC_SUBI) begin
      dec.illegal = 1'b0;
      dec.rf_we   = 1'b1;
      dec.use_imm = 1'b1;
      dec.sub     = (op10 == OPC_SUBI);
      dec.imm     = {{(XLEN-IMM_W){1'b0}}, instr[21:10]};
    end else if ((op11 == OPC_LOAD || op11 == OPC_STOR) && op2_zero) begin
      dec.illegal = 1'b0;
      dec.use_imm = 1'b1;
      dec.imm     = {{(XLEN-OFS_W){instr[20]}}, instr[20:12]};
      dec.mem_rd  = (op11 == OPC_LOAD);
      dec.rf_we   = (op11 == OPC_LOAD);
      dec.mem_we  = (op11 == OPC_STOR);
    end
  end
endmodule

// File: rtl/mls_regfile.sv
module mls_regfile import mls_pkg::*; (
  input  logic              clk,
  input  logic [REG_AW-1:0] ra_idx,
  output logic [XLEN-1:0]   ra_val,
  input  logic [REG_AW-1:0] rb_idx,
  output logic [XLEN-1:0]   rb_val,
  input  logic [REG_AW-1:0] rc_idx,
  output logic [XLEN-1:0]   rc_val,
  input  logic              we,
  input  logic [REG_AW-1:0] wr_idx,
  input  logic [XLEN-1:0]   wr_val
);
  localparam logic [REG_AW-1:0] ZERO_IDX = REG_AW'(NREGS - 1);

  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we && wr_idx != ZERO_IDX) regs[wr_idx] <= wr_val;
  end

  assign ra_val = (ra_idx == ZERO_IDX) ? '0 : regs[ra_idx];
  assign rb_val = (rb_idx == ZERO_IDX) ? '0 : regs[rb_idx];
  assign rc_val = (rc_idx == ZERO_IDX) ? '0 : regs[rc_idx];
endmodule

// File: rtl/mls_imem.sv
module mls_imem import mls_pkg::*; #(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_idx,
  input  logic [INSTR_W-1:0] wr_word,
  input  logic [AW-1:0]      rd_idx,
  output logic [INSTR_W-1:0] rd_word
);
  logic [INSTR_W-1:0] words [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_idx] <= wr_word;
  end

  assign rd_word = words[rd_idx];
endmodule

// File: rtl/mls_dmem.sv
module mls_dmem import mls_pkg::*; #(
  parameter int BYTES = 512,
  localparam int LANES = XLEN / 8,
  localparam int LSB_W = $clog2(LANES),
  localparam int BAW   = $clog2(BYTES),
  localparam int ROWS  = BYTES / LANES,
  localparam int RAW   = BAW - LSB_W
) (
  input  logic            clk,
  input  logic            ld_we,
  input  logic [BAW-1:0]  ld_addr,
  input  logic [7:0]      ld_byte,
  input  logic [BAW-1:0]  acc_addr,
  input  logic            acc_we,
  input  logic [XLEN-1:0] acc_wdata,
  output logic [XLEN-1:0] acc_rdata,
  input  logic [BAW-1:0]  peek_addr,
  output logic [XLEN-1:0] peek_data
);
  logic [7:0] lane_acc  [LANES];
  logic [7:0] lane_peek [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0]       bank [ROWS];
    logic [LSB_W-1:0] k_acc;
    logic [RAW-1:0]   row_acc;
    logic [RAW-1:0]   row_peek;

    assign k_acc    = LSB_W'(l) - acc_addr[LSB_W-1:0];
    assign row_acc  = acc_addr[BAW-1:LSB_W]
                    + RAW'(LSB_W'(l) < acc_addr[LSB_W-1:0]);
    assign row_peek = peek_addr[BAW-1:LSB_W]
                    + RAW'(LSB_W'(l) < peek_addr[LSB_W-1:0]);

    always_ff @(posedge clk) begin
      if (ld_we && ld_addr[LSB_W-1:0] == LSB_W'(l))
        bank[ld_addr[BAW-1:LSB_W]] <= ld_byte;
      else if (acc_we)
        bank[row_acc] <= acc_wdata[8*k_acc +: 8];
    end

    assign lane_acc[l]  = bank[row_acc];
    assign lane_peek[l] = bank[row_peek];
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      acc_rdata[8*k +: 8]  = lane_acc[LSB_W'(acc_addr[LSB_W-1:0] + LSB_W'(k))];
      peek_data[8*k +: 8]  = lane_peek[LSB_W'(peek_addr[LSB_W-1:0] + LSB_W'(k))];
    end
  end
endmodule

// File: rtl/mini_ls_core.sv
module mini_ls_core import mls_pkg::*; #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_BYTES = 512,
  localparam int IM_AW = $clog2(IMEM_WORDS),
  localparam int DM_AW = $clog2(DMEM_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_we,
  input  logic               ld_dmem,
  input  logic [DM_AW-1:0]   ld_addr,
  input  logic [INSTR_W-1:0] ld_data,
  input  logic [REG_AW-1:0]  dbg_reg_addr,
  output logic [XLEN-1:0]    dbg_reg_data,
  input  logic [DM_AW-1:0]   dbg_mem_addr,
  output logic [XLEN-1:0]    dbg_mem_data,
  output logic               halt
);
  logic [XLEN-1:0]    pc_q;
  logic               halt_q;
  logic [INSTR_W-1:0] instr;
  dec_t               dec;
  logic [XLEN-1:0]    rs_a, rs_b, opnd_b, alu_res, ld_val, wb_val;
  logic [XLEN-1:0]    dbg_rf, dbg_dm;
  logic [REG_AW-1:0]  rb_sel;
  logic               exec_ok, rf_we, dm_we, illegal_w;

  mls_imem #(.WORDS(IMEM_WORDS)) u_imem (
    .clk     (clk),
    .wr_en   (ld_we && !ld_dmem),
    .wr_idx  (ld_addr[IM_AW-1:0]),
    .wr_word (ld_data),
    .rd_idx  (pc_q[IM_AW+1:2]),
    .rd_word (instr)
  );

  mls_decode u_dec (.instr(instr), .dec(dec));

  assign illegal_w = dec.illegal;
  assign rb_sel    = dec.mem_we ? dec.rd : dec.rm;

  mls_regfile u_rf (
    .clk    (clk),
    .ra_idx (dec.rn),
    .ra_val (rs_a),
    .rb_idx (rb_sel),
    .rb_val (rs_b),
    .rc_idx (dbg_reg_addr),
    .rc_val (dbg_rf),
    .we     (rf_we),
    .wr_idx (dec.rd),
    .wr_val (wb_val)
  );

  assign opnd_b  = dec.use_imm ? dec.imm : rs_b;
  assign alu_res = dec.sub ? (rs_a - opnd_b) : (rs_a + opnd_b);
  assign exec_ok = !rst && !halt_q && !dec.illegal;
  assign rf_we   = exec_ok && dec.rf_we;
  assign dm_we   = exec_ok && dec.mem_we;
  assign wb_val  = dec.mem_rd ? ld_val : alu_res;

  mls_dmem #(.BYTES(DMEM_BYTES)) u_dmem (
    .clk       (clk),
    .ld_we     (ld_we && ld_dmem),
    .ld_addr   (ld_addr),
    .ld_byte   (ld_data[7:0]),
    .acc_addr  (alu_res[DM_AW-1:0]),
    .acc_we    (dm_we),
    .acc_wdata (rs_b),
    .acc_rdata (ld_val),
    .peek_addr (dbg_mem_addr),
    .peek_data (dbg_dm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      halt_q <= 1'b0;
    end else if (!halt_q) begin
      if (dec.illegal) halt_q <= 1'b1;
      else             pc_q   <= pc_q + XLEN'(4);
    end
    dbg_reg_data <= dbg_rf;
    dbg_mem_data <= dbg_dm;
  end

  assign halt = halt_q;
endmodule

// File: rtl/mls_checker.sv
module mls_checker import mls_pkg::*; (
  input logic              clk,
  input logic              rst,
  input logic [XLEN-1:0]   pc,
  input logic              halt,
  input logic              illegal,
  input logic [REG_AW-1:0] dbg_reg_addr,
  input logic [XLEN-1:0]   dbg_reg_data
);
  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (pc == '0 && !halt));

  assert_pc_advance_R9: assert property (@(posedge clk) disable iff (rst)
    (!halt && !illegal) |=> (pc == $past(pc) + XLEN'(4)));

  assert_illegal_halts_R8: assert property (@(posedge clk) disable iff (rst)
    (!halt && illegal) |=> halt);

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);

  assert_halt_freezes_pc_R8: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(pc));

  assert_zero_reg_dbg_R7: assert property (@(posedge clk) disable iff (rst)
    (dbg_reg_addr == REG_AW'(NREGS - 1)) |=> (dbg_reg_data == '0));
endmodule

bind mini_ls_core mls_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .pc           (pc_q),
  .halt         (halt),
  .illegal      (illegal_w),
  .dbg_reg_addr (dbg_reg_addr),
  .dbg_reg_data (dbg_reg_data)
);

// File: tb/mini_ls_core_test.sv
module mini_ls_core_test;
  localparam int IMW = 64;
  localparam int DMB = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0, ld_dmem = 1'b0;
  logic [8:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  dbg_reg_addr = '0;
  logic [63:0] dbg_reg_data;
  logic [8:0]  dbg_mem_addr = '0;
  logic [63:0] dbg_mem_data;
  logic        halt;

  int compared = 0, mismatched = 0;

  always #10 clk = ~clk;

  mini_ls_core #(.IMEM_WORDS(IMW), .DMEM_BYTES(DMB)) uut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
    .ld_data(ld_data), .dbg_reg_addr(dbg_reg_addr), .dbg_reg_data(dbg_reg_data),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data), .halt(halt)
  );

  // reference model state
  logic [63:0] mregs [32];
  logic [31:0] known = '0;
  logic [7:0]  mmem [DMB];
  logic [7:0]  init_mem [DMB];
  logic [31:0] prog [IMW];
  int          n_words, steps;
  bit          mhalt;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] er(input logic [10:0] op, input int rm, input int rn, input int rd);
    return {op, 5'(rm), 6'd0, 5'(rn), 5'(rd)};
  endfunction
  function automatic logic [31:0] ei(input logic [9:0] op, input int imm, input int rn, input int rd);
    return {op, 12'(imm), 5'(rn), 5'(rd)};
  endfunction
  function automatic logic [31:0] ed(input logic [10:0] op, input int ofs, input int rn, input int rt);
    return {op, 9'(ofs), 2'b00, 5'(rn), 5'(rt)};
  endfunction

  function automatic logic [63:0] rv(input logic [4:0] i);
    return (i == 5'd31) ? 64'd0 : mregs[i];
  endfunction
  function automatic void wr(input logic [4:0] i, input logic [63:0] v);
    if (i != 5'd31) begin mregs[i] = v; known[i] = 1'b1; end
  endfunction

  task automatic mexec(input logic [31:0] w);
    logic [63:0] a, b, ea;
    if (mhalt) return;
    a = rv(w[9:5]);
    if ((w[31:21] == 11'd1112 || w[31:21] == 11'd1624) && w[15:10] == 6'd0) begin
      b = rv(w[20:16]);
      wr(w[4:0], (w[31:21] == 11'd1112) ? a + b : a - b);
    end else if (w[31:22] == 10'd580 || w[31:22] == 10'd836) begin
      b = {52'd0, w[21:10]};
      wr(w[4:0], (w[31:22] == 10'd580) ? a + b : a - b);
    end else if ((w[31:21] == 11'd1986 || w[31:21] == 11'd1984) && w[11:10] == 2'd0) begin
      ea = a + {{55{w[20]}}, w[20:12]};
      if (w[31:21] == 11'd1986) begin
        b = '0;
        for (int k = 0; k < 8; k++) b[8*k +: 8] = mmem[int'((ea + 64'(k)) & 64'(DMB-1))];
        wr(w[4:0], b);
      end else begin
        b = rv(w[4:0]);
        for (int k = 0; k < 8; k++) mmem[int'((ea + 64'(k)) & 64'(DMB-1))] = b[8*k +: 8];
      end
    end else mhalt = 1'b1;
    if (!mhalt) steps++;
  endtask

  task automatic begin_prog(input int seed);
    for (int i = 0; i < DMB; i++) begin
      init_mem[i] = 8'(i * (2 * seed + 13) + 7 * seed + 1);
      mmem[i] = init_mem[i];
    end
    n_words = 0; steps = 0; mhalt = 1'b0;
  endtask

  task automatic emit(input logic [31:0] w);
    prog[n_words] = w;
    n_words++;
    mexec(w);
  endtask

  task automatic rd_reg(input int a, output logic [63:0] v);
    dbg_reg_addr = 5'(a);
    @(negedge clk);
    v = dbg_reg_data;
  endtask
  task automatic rd_mem(input int a, output logic [63:0] v);
    dbg_mem_addr = 9'(a);
    @(negedge clk);
    v = dbg_mem_data;
  endtask

  task automatic run_prog(input string req);
    logic [63:0] v, e;
    rst = 1'b1;
    ld_we = 1'b1;
    ld_dmem = 1'b0;
    for (int i = 0; i < IMW; i++) begin
      ld_addr = 9'(i); ld_data = (i < n_words) ? prog[i] : 32'd0;
      @(negedge clk);
    end
    ld_dmem = 1'b1;
    for (int i = 0; i < DMB; i++) begin
      ld_addr = 9'(i); ld_data = {24'd0, init_mem[i]};
      @(negedge clk);
    end
    ld_we = 1'b0;
    check("R9 reset halt", {63'd0, halt}, 64'd0);
    rst = 1'b0;
    repeat (steps) @(negedge clk);
    check("R8 R9 halt timing", {63'd0, halt}, 64'd0);
    @(negedge clk);
    check("R8 halt rises", {63'd0, halt}, 64'd1);
    repeat (3) @(negedge clk);
    check("R8 halt sticky", {63'd0, halt}, 64'd1);
    for (int r = 0; r < 32; r++) begin
      if (known[r] || r == 31) begin
        rd_reg(r, v);
        check((r == 31) ? "R7 zero reg" : req, v, rv(5'(r)));
      end
    end
    for (int a = 0; a <= DMB - 8; a++) begin
      rd_mem(a, v);
      e = '0;
      for (int k = 0; k < 8; k++) e[8*k +: 8] = mmem[a + k];
      check("R6 R10 memory", v, e);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    logic [63:0] v, e;
    repeat (3) @(negedge clk);

    // Program A: load, add, add one, store back at offset 240
    begin_prog(1);
    emit(ei(10'd580, 16, 31, 10));
    emit(ei(10'd580, 12'h123, 31, 20));
    emit(ei(10'd580, 100, 31, 21));
    emit(32'h8B150289);                 // R1 literal encoding
    emit(ed(11'd1986, 240, 10, 9));
    emit(er(11'd1112, 9, 21, 9));
    emit(ei(10'd580, 1, 9, 9));
    emit(ed(11'd1984, 240, 10, 9));
    emit(ei(10'd580, 5, 31, 31));        // R7 discarded write
    emit(er(11'd1112, 31, 31, 11));
    run_prog("R1 R3 R5");
    e = '0;
    for (int k = 0; k < 8; k++) e[8*k +: 8] = init_mem[256 + k];
    e = e + 64'd101;
    rd_mem(256, v);
    check("R6 stored sum", v, e);
    rd_reg(11, v);
    check("R7 zero sources", v, 64'd0);

    // Program B: arithmetic sweep, wrap-around, unaligned accesses
    begin_prog(2);
    for (int i = 1; i <= 8; i++) emit(ei(10'd580, (i * 739 + 5) & 12'hFFF, 31, i));
    for (int i = 0; i < 24; i++) begin
      int s1 = 1 + (i % 8), s2 = 1 + ((i * 3 + 2) % 8), d = 1 + ((i * 5 + 1) % 8);
      case (i % 4)
        0: emit(er(11'd1112, s2, s1, d));
        1: emit(er(11'd1624, s2, s1, d));          // R2
        2: emit(ei(10'd580, (i * 911) & 12'hFFF, s1, d));
        default: emit(ei(10'd836, (i * 457 + 9) & 12'hFFF, s1, d)); // R4
      endcase
    end
    emit(ei(10'd836, 1, 31, 16));        // R4 wraps to all ones
    emit(ei(10'd580, 1, 16, 17));        // R3 wraps to zero
    emit(ei(10'd580, 4095, 31, 18));     // R3 largest immediate
    emit(er(11'd1624, 18, 31, 19));      // R2 negative result
    emit(ei(10'd580, 256, 31, 12));
    for (int j = 0; j < 10; j++) begin
      emit(ed(11'd1984, -256 + j * 55, 12, 1 + (j % 8)));
      emit(ed(11'd1986, -253 + j * 55, 12, 20 + (j % 4)));
    end
    emit(ed(11'd1984, 255, 12, 19));     // R6 wraps past end of memory
    emit(ed(11'd1986, 252, 12, 24));     // R5 wraps on load
    emit(ed(11'd1984, -1, 12, 16));
    run_prog("R2 R4 R5");

    // Program C: unrecognised words stop the core
    for (int b = 0; b < 3; b++) begin
      logic [31:0] bad;
      case (b)
        0: bad = {11'd1112, 5'd2, 6'd1, 5'd3, 5'd4};        // nonzero shift field
        1: bad = {11'd1986, 9'd8, 2'b01, 5'd31, 5'd5};      // nonzero transfer extension
        default: bad = 32'hFFFF_FFFF;
      endcase
      begin_prog(3 + b);
      emit(ei(10'd580, 40 + b, 31, 14));
      emit(bad);
      emit(ei(10'd580, 999, 31, 14));
      emit(ed(11'd1984, 8, 31, 14));
      run_prog("R8 no commit");
      rd_reg(14, v);
      check("R8 register after halt", v, 64'(40 + b));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule